// File: doc/BRIEF.md
# Salsa20 Keystream Block Generator (128-bit key, two shared quarter-round units)

This block computes one 512-bit Salsa20/20 keystream block per request and returns it XORed with a 512-bit data word. Pass an all-zero data word to read the raw keystream. Pass plaintext or ciphertext to encrypt or decrypt, because the XOR works the same in both directions.

The 16x32-bit working matrix is built from four sources: the 128-bit key, which is used twice, a 64-bit nonce, a 64-bit block counter, and the four constant words of the 16-byte-key expansion.

A phase controller runs ten double-rounds. Each double-round has four half-round phases:

- column groups 0 and 1
- column groups 2 and 3
- row groups 0 and 1
- row groups 2 and 3

In each phase, two quarter-round step units work side by side. Each unit updates one word per cycle, so a quarter-round takes four cycles and a double-round takes sixteen. The rounded matrix is then added word by word to the saved original matrix, and the result is converted to the byte stream.

An internal 64-bit block counter can be loaded. It advances by one after every finished block, so a run of starts walks through consecutive keystream blocks.

Top module: `salsa20_ks`

## Requirements
- R1: While reset is held and after it is released, `done` and `busy` are 0 and `dataOut` is all zeros until the first block completes.
- R2: Byte conventions and result:
  - Byte i of a vector is the eight bits starting at the MSB end: bits [W-1-8i -: 8].
  - Key and nonce bytes are read little-endian into words.
  - The matrix has constant words 0x61707865, 0x3120646e, 0x79622d36 and 0x6b206574 at positions 0, 5, 10 and 15.
  - Key words 0..3 sit at positions 1..4 and again at 11..14. Nonce words sit at positions 6 and 7.
  - The counter's low and high 32 bits sit at positions 8 and 9.
  - After ten double-rounds and the feed-forward addition, output word j is written little-endian as bytes 4j..4j+3.
  - `dataOut` is this keystream XOR the data word.
- R3: The data word is captured on the edge that accepts `start`. Later changes to `dataIn`, `key` or `nonce` do not alter the block being computed.
- R4: `done` is high for exactly one cycle, on the 161st rising edge after the edge that accepted `start`. `busy` is high from the accepting edge until `done` rises, and low while `done` is high.
- R5: Each completed block advances the internal counter by one, so the next start without a load uses the previous block's counter plus one.
- R6: `ctrLoad` while idle loads `ctrInit`. If it is given together with `start`, the new block already uses `ctrInit`.
- R7: A `start` while `busy` is ignored. The running block finishes on its original schedule with its original result.
- R8: A `ctrLoad` while `busy` is ignored. The counter sequence continues from the running block.
- R9: The block counter wraps from 0xFFFFFFFFFFFFFFFF to 0.
- R10: `dataOut` changes only on the cycle in which `done` rises, and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one block (accepted only when idle) |
| ctrLoad | input | 1 | Load the block counter from ctrInit (only when idle) |
| key | input | 128 | Secret key, byte 0 in the top byte |
| nonce | input | 64 | Message nonce, byte 0 in the top byte |
| ctrInit | input | 64 | Counter value for a load |
| dataIn | input | 512 | Data word to combine with the keystream |
| dataOut | output | 512 | Keystream XOR data, byte 0 in the top byte |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse when dataOut is updated |

## Verification
Any wrong word index, rotation amount or phase ordering inside the rounds spreads through the whole matrix within one double-round. It therefore shows as a mismatch in most of the 512 output bits at the very next `done`, which is 161 cycles after the start.

A counter slip or a step counter off by one shows in two ways: `done` lands on the wrong cycle, or the following block carries the wrong counter value. Each block is compared against an independent software model, so such a fault is caught at the next completion.

Faults in accepting or ignoring requests during a run show up as shifted `done` timing or a changed result for the running block.

// File: rtl/salsa20_pkg.sv
package salsa20_pkg;
  typedef logic [31:0] word_t;

  // control strobes from sequencer to datapath
  typedef struct packed {
    logic       load;    // capture the initial matrix and data
    logic       ctrSet;  // load the block counter
    logic       step;    // apply one quarter-round step in both units
    logic [1:0] phase;   // half-round phase within the double-round
    logic [1:0] sub;     // step within the quarter-round
    logic       fin;     // feed-forward, output and counter advance
  } ctl_t;

  localparam word_t EXP0 = 32'h61707865;
  localparam word_t EXP1 = 32'h3120646e;
  localparam word_t EXP2 = 32'h79622d36;
  localparam word_t EXP3 = 32'h6b206574;

  function automatic word_t bswap(word_t w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic word_t rotl(word_t w, int n);
    return (w << n) | (w >> (32 - n));
  endfunction

  // matrix slot of member k of group g in a column or row round
  function automatic logic [3:0] slot(logic isRow, logic [1:0] g, logic [1:0] k);
    logic [1:0] m;
    m = g + k;
    return isRow ? {g, m} : {m, g};
  endfunction
endpackage

// File: rtl/salsa20_qr_step.sv
module salsa20_qr_step
  import salsa20_pkg::*;
(
  input  word_t      wa,
  input  word_t      wb,
  input  word_t      wc,
  input  word_t      wd,
  input  logic [1:0] sub,
  output word_t      newWord,
  output logic [1:0] tgt
);
  always_comb begin
    unique case (sub)
      2'd0: begin newWord = wb ^ rotl(wa + wd, 7);  tgt = 2'd1; end
      2'd1: begin newWord = wc ^ rotl(wb + wa, 9);  tgt = 2'd2; end
      2'd2: begin newWord = wd ^ rotl(wc + wb, 13); tgt = 2'd3; end
      default: begin newWord = wa ^ rotl(wd + wc, 18); tgt = 2'd0; end
    endcase
  end
endmodule

// File: rtl/salsa20_ctrl.sv
module salsa20_ctrl
  import salsa20_pkg::*;
#(
  parameter int NDR = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic ctrLoad,
  output ctl_t ctl,
  output logic busy,
  output logic done
);
  localparam int DRW = (NDR > 1) ? $clog2(NDR) : 1;
  localparam logic [DRW-1:0] LAST_DR = DRW'(NDR - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state;
  logic [1:0] sub, phase;
  logic [DRW-1:0] dr;

  always_comb begin
    ctl.load   = (state == S_IDLE) && start;
    ctl.ctrSet = (state == S_IDLE) && ctrLoad;
    ctl.step   = (state == S_RUN);
    ctl.phase  = phase;
    ctl.sub    = sub;
    ctl.fin    = (state == S_FIN);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      sub   <= '0;
      phase <= '0;
      dr    <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == S_FIN);
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          sub   <= '0;
          phase <= '0;
          dr    <= '0;
        end
        S_RUN: begin
          sub <= sub + 2'd1;
          if (sub == 2'd3) begin
            phase <= phase + 2'd1;
            if (phase == 2'd3) begin
              if (dr == LAST_DR) state <= S_FIN;
              else dr <= dr + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/salsa20_dp.sv
module salsa20_dp
  import salsa20_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  ctl_t           ctl,
  input  logic [127:0]   key,
  input  logic [63:0]    nonce,
  input  logic [63:0]    ctrInit,
  input  logic [511:0]   dataIn,
  output logic [511:0]   dataOut
);
  word_t x [16];
  word_t orig [16];
  word_t initMat [16];
  logic [63:0]  ctrReg, ctrNow;
  logic [511:0] dataHold, ks;
  word_t qrNew [2];
  logic [3:0] qrIdx [2];
  logic isRow;

  assign ctrNow = ctl.ctrSet ? ctrInit : ctrReg;
  assign isRow  = ctl.phase[1];

  always_comb begin
    initMat[0]  = EXP0;
    initMat[5]  = EXP1;
    initMat[10] = EXP2;
    initMat[15] = EXP3;
    for (int i = 0; i < 4; i++) begin
      initMat[1 + i]  = bswap(key[127 - 32*i -: 32]);
      initMat[11 + i] = bswap(key[127 - 32*i -: 32]);
    end
    initMat[6] = bswap(nonce[63:32]);
    initMat[7] = bswap(nonce[31:0]);
    initMat[8] = ctrNow[31:0];
    initMat[9] = ctrNow[63:32];
  end

  for (genvar u = 0; u < 2; u++) begin : g_qr
    logic [1:0] grp, tgt;
    logic [3:0] ia, ib, ic, id;
    assign grp = {ctl.phase[0], 1'(u)};
    assign ia = slot(isRow, grp, 2'd0);
    assign ib = slot(isRow, grp, 2'd1);
    assign ic = slot(isRow, grp, 2'd2);
    assign id = slot(isRow, grp, 2'd3);
    salsa20_qr_step u_step (
      .wa(x[ia]), .wb(x[ib]), .wc(x[ic]), .wd(x[id]),
      .sub(ctl.sub), .newWord(qrNew[u]), .tgt(tgt)
    );
    assign qrIdx[u] = slot(isRow, grp, tgt);
  end

  always_comb begin
    for (int j = 0; j < 16; j++)
      ks[511 - 32*j -: 32] = bswap(x[j] + orig[j]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < 16; j++) begin
        x[j]    <= '0;
        orig[j] <= '0;
      end
      ctrReg   <= '0;
      dataHold <= '0;
      dataOut  <= '0;
    end else begin
      if (ctl.ctrSet) ctrReg <= ctrInit;
      if (ctl.load) begin
        for (int j = 0; j < 16; j++) begin
          x[j]    <= initMat[j];
          orig[j] <= initMat[j];
        end
        dataHold <= dataIn;
      end else if (ctl.step) begin
        x[qrIdx[0]] <= qrNew[0];
        x[qrIdx[1]] <= qrNew[1];
      end
      if (ctl.fin) begin
        dataOut <= ks ^ dataHold;
        ctrReg  <= {orig[9], orig[8]} + 64'd1;
      end
    end
  end
endmodule

// File: rtl/salsa20_ks.sv
module salsa20_ks
  import salsa20_pkg::*;
#(
  parameter int NDR = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         ctrLoad,
  input  logic [127:0] key,
  input  logic [63:0]  nonce,
  input  logic [63:0]  ctrInit,
  input  logic [511:0] dataIn,
  output logic [511:0] dataOut,
  output logic         busy,
  output logic         done
);
  ctl_t ctl;

  salsa20_ctrl #(.NDR(NDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctrLoad(ctrLoad),
    .ctl(ctl), .busy(busy), .done(done)
  );

  salsa20_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .key(key), .nonce(nonce),
    .ctrInit(ctrInit), .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/salsa20_ks_chk.sv
module salsa20_ks_chk #(
  parameter int NDR = 10
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [511:0] dataOut
);
  localparam int LAT = 16 * NDR + 1;
  logic [15:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) runCnt <= '0;
    else runCnt <= runCnt + 16'd1;
  end

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_busy_end_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  p_busy_from_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  p_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> runCnt == 16'(LAT));
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(dataOut));
endmodule

bind salsa20_ks salsa20_ks_chk #(.NDR(NDR)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .dataOut(dataOut)
);

// File: tb/salsa20_ks_tb.sv
module salsa20_ks_tb;
  typedef logic [31:0] w_t;
  typedef w_t mat_t [16];

  logic clk = 0;
  logic rstN = 0;
  logic start = 0, ctrLoad = 0;
  logic [127:0] key = '0;
  logic [63:0]  nonce = '0, ctrInit = '0;
  logic [511:0] dataIn = '0;
  logic [511:0] dataOut;
  logic busy, done;

  int checks = 0, errors = 0;
  logic [511:0] expQ[$];
  string reqQ[$];
  logic [63:0] expCtr = '0;

  always #10 clk = ~clk;  // 50 MHz

  salsa20_ks u_dut (
    .clk(clk), .rstN(rstN), .start(start), .ctrLoad(ctrLoad), .key(key),
    .nonce(nonce), .ctrInit(ctrInit), .dataIn(dataIn), .dataOut(dataOut),
    .busy(busy), .done(done)
  );

  function automatic w_t rl(w_t v, int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic w_t le(logic [31:0] b);  // bytes b0..b3 from top
    return {b[7:0], b[15:8], b[23:16], b[31:24]};
  endfunction

  function automatic mat_t qr(mat_t m, int a, int b, int c, int d);
    m[b] = m[b] ^ rl(m[a] + m[d], 7);
    m[c] = m[c] ^ rl(m[b] + m[a], 9);
    m[d] = m[d] ^ rl(m[c] + m[b], 13);
    m[a] = m[a] ^ rl(m[d] + m[c], 18);
    return m;
  endfunction

  function automatic logic [511:0] model(logic [127:0] k, logic [63:0] n,
                                         logic [63:0] ctr, logic [511:0] d);
    mat_t s, z;
    logic [511:0] r;
    s[0] = 32'h61707865; s[5] = 32'h3120646e;
    s[10] = 32'h79622d36; s[15] = 32'h6b206574;
    for (int i = 0; i < 4; i++) begin
      s[1+i]  = le(k[127-32*i -: 32]);
      s[11+i] = le(k[127-32*i -: 32]);
    end
    s[6] = le(n[63:32]); s[7] = le(n[31:0]);
    s[8] = ctr[31:0];    s[9] = ctr[63:32];
    z = s;
    for (int r2 = 0; r2 < 10; r2++) begin
      z = qr(z, 0, 4, 8, 12);  z = qr(z, 5, 9, 13, 1);
      z = qr(z, 10, 14, 2, 6); z = qr(z, 15, 3, 7, 11);
      z = qr(z, 0, 1, 2, 3);   z = qr(z, 5, 6, 7, 4);
      z = qr(z, 10, 11, 8, 9); z = qr(z, 15, 12, 13, 14);
    end
    for (int j = 0; j < 16; j++) r[511-32*j -: 32] = le(z[j] + s[j]);
    return r ^ d;
  endfunction

  task automatic check(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pop expected block on every done
  logic prevDone = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone && done) check(0, "R4", "done longer than one cycle", 1, 0);
      if (done) begin
        if (expQ.size() == 0) check(0, "R7", "unexpected done", 1, 0);
        else begin
          automatic logic [511:0] e = expQ.pop_front();
          automatic string rq = reqQ.pop_front();
          check(dataOut === e, rq, "block result", dataOut, e);
        end
      end
    end
    prevDone = done;
  end

  // driver: push expected result and run one block
  task automatic runBlock(logic [127:0] k, logic [63:0] n, logic [511:0] d,
                          bit doLoad, logic [63:0] cv, bit disturb, string req);
    int cyc;
    if (doLoad) expCtr = cv;
    expQ.push_back(model(k, n, expCtr, d));
    reqQ.push_back(req);
    start = 1; ctrLoad = doLoad; ctrInit = cv; key = k; nonce = n; dataIn = d;
    @(negedge clk);
    start = 0; ctrLoad = 0;
    cyc = 1;
    check(busy === 1'b1, "R4", "busy after start", busy, 1);
    while (!done && cyc < 400) begin
      if (disturb && cyc == 50) begin  // R7 R8 R3: mid-run disturbance
        start = 1; ctrLoad = 1; ctrInit = 64'h5555;
        dataIn = ~d; key = ~k; nonce = ~n;
      end else begin
        start = 0; ctrLoad = 0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 0; ctrLoad = 0;
    // done visible after the 161st edge past the accepting edge
    check(cyc == 162, "R4", "done latency", 512'(cyc), 512'd162);
    check(busy === 1'b0, "R4", "busy low with done", busy, 0);
    expCtr = expCtr + 64'd1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", "run hung", 0, 1);
    summary();
  end

  initial begin
    logic [511:0] held;
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R1", "done in reset", done, 0);
    check(busy === 1'b0, "R1", "busy in reset", busy, 0);
    rstN = 1;
    @(negedge clk);
    check(dataOut === '0, "R1", "dataOut after reset", dataOut, 0);
    check(done === 1'b0 && busy === 1'b0, "R1", "idle after reset", {done, busy}, 0);

    // R2 R6: raw keystream, counter loaded with start
    runBlock(128'h000102030405060708090a0b0c0d0e0f, 64'h1011121314151617, '0,
             1, 64'd0, 0, "R2/R6");
    // R5 R3: auto-advanced counter, data XOR
    runBlock(128'h000102030405060708090a0b0c0d0e0f, 64'h1011121314151617,
             {16{32'hdeadbeef}}, 0, 64'd0, 0, "R5/R3");
    // R7 R8 R3: start, load and input changes while busy are ignored
    runBlock(128'hffeeddccbbaa99887766554433221100, 64'h0f1e2d3c4b5a6978,
             {8{64'h0123456789abcdef}}, 0, 64'd0, 1, "R7/R3");
    runBlock(128'h8badf00d8badf00d8badf00d8badf00d, 64'h0, '0, 0, 64'd0, 0, "R8");
    // R6: load while idle without start, then start
    ctrLoad = 1; ctrInit = 64'hffffffffffffffff; @(negedge clk);
    ctrLoad = 0; expCtr = 64'hffffffffffffffff; @(negedge clk);
    runBlock(128'h0123456789abcdef0123456789abcdef, 64'habcdef0123456789, '0,
             0, 64'd0, 0, "R6");
    // R9: wrap to zero
    runBlock(128'h0123456789abcdef0123456789abcdef, 64'habcdef0123456789, '0,
             0, 64'd0, 0, "R9");
    // R10: output held while idle with input activity
    held = dataOut;
    for (int i = 0; i < 20; i++) begin
      dataIn = {16{32'(i)}}; key = {4{32'(i * 7)}};
      @(negedge clk);
    end
    check(dataOut === held, "R10", "dataOut held", dataOut, held);
    check(done === 1'b0, "R10", "no spurious done", done, 0);
    check(expQ.size() == 0, "R4", "all blocks completed", 512'(expQ.size()), 0);
    summary();
  end
endmodule